// File: doc/BRIEF.md
# MSI-X Capability Register Block

This block holds the 12-byte MSI-X capability structure of a function and exposes it through a simple dword-wide configuration port. Software reads three dwords. The first carries the capability identifier and the message-control halfword. The second and third carry the table location and the pending-array location, each with its BAR indicator in the low three bits. Only two bits can be changed by software: the enable flag and the function-wide mask flag, both in the top byte of the first dword. Every other bit is fixed at elaboration.

The locations are computed from the parameterised size of the function's original BAR. The BAR is doubled, with a 4 KB floor, so that the MSI-X table sits in the upper half of the enlarged window. The pending array sits 2 KB above the table.

When software writes the control byte and the result leaves MSI-X enabled, the block gives a one-cycle pulse to drop the legacy interrupt line. If the function is also left unmasked, a second pulse tells a separate vector engine to rescan its pending vectors. Both pulses appear in the cycle after the write. Elaboration stops if the vector count is outside 1..32, the BAR indicator is above 5, or the original BAR size is above 2 GB.

Top module: `msixcap_regs`

## Requirements
- R1: Dword 0 (cfg_addr=0) reads with bits 7:0 = 0x11, bits 15:8 = 0, and bits 26:16 = VEC_COUNT-1. Bits 29:27 read 0. Bit 31 is the enable flag and bit 30 is the mask-all flag.
- R2: After reset, the enable flag and the mask-all flag are both 0, and the two pulse outputs are low.
- R3: A write to dword 0 with cfg_be[3] set loads only bits 31 and 30 from cfg_wdata. Writing all ones leaves every other bit of dword 0 at its fixed value.
- R4: These writes change no flag and raise no pulse: a write to dwords 1, 2 or 3, and a write to dword 0 with cfg_be[3] clear.
- R5: Dword 1 reads ADJ|BIR and dword 2 reads (ADJ+0x800)|BIR. ADJ is 0 when the original BAR size is 0. It is 0x1000 when the size is below 0x1000. Otherwise it is the original size. Dword 3 reads 0.
- R6: bar_size_new is 0x1000 when the original BAR size is 0. Otherwise it is twice ADJ.
- R7: A control-byte write that leaves the enable flag at 1 makes intx_deassert high for exactly the one cycle after the write.
- R8: rescan_req pulses in the same cycle as intx_deassert only if the same write also leaves the mask-all flag at 0.
- R9: A control-byte write that leaves the enable flag at 0 raises neither pulse.
- R10: The outputs msix_en and func_mask equal bits 31 and 30 of dword 0. They update in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 2 | Dword select (address bits 3:2) |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected dword |
| msix_en | output | 1 | MSI-X enable flag |
| func_mask | output | 1 | Function mask-all flag |
| intx_deassert | output | 1 | One-cycle legacy interrupt drop pulse |
| rescan_req | output | 1 | One-cycle pending-vector rescan request |
| bar_size_new | output | 33 | Enlarged BAR size in bytes |

## Verification
The legacy-line drop and the rescan request can both come from a single control-byte write, in the same cycle. The bench writes the control byte with enable set and mask clear, then with enable and mask both set, then with enable clear. In the cycle after each write it checks that the first write raises both pulses together. The second must raise only the drop pulse and the third neither. One cycle later both pulses must be low again.

// File: rtl/msixcap_regs.sv
module msixcap_regs #(
  parameter int          VEC_COUNT      = 32,
  parameter logic [31:0] ORIG_BAR_BYTES = 32'h0000_4000,
  parameter int          BIR            = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:2]  cfg_addr,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        msix_en,
  output logic        func_mask,
  output logic        intx_deassert,
  output logic        rescan_req,
  output logic [32:0] bar_size_new
);
  localparam logic [31:0] PAGE   = 32'h0000_1000;
  localparam logic [31:0] ADJ    = (ORIG_BAR_BYTES == 0) ? 32'h0 :
                                   (ORIG_BAR_BYTES < PAGE) ? PAGE : ORIG_BAR_BYTES;
  localparam logic [32:0] NEWSZ  = (ORIG_BAR_BYTES == 0) ? {1'b0, PAGE} : {ADJ, 1'b0};
  localparam logic [31:0] BIRV   = 32'(BIR);
  localparam logic [31:0] TBL    = ADJ | BIRV;
  localparam logic [31:0] PBA    = (ADJ + 32'h800) | BIRV;
  localparam logic [10:0] QSIZE  = 11'(VEC_COUNT - 1);

  if (VEC_COUNT < 1 || VEC_COUNT > 32) begin : g_bad_count
    $error("msixcap_regs: VEC_COUNT out of range");
  end
  if (ORIG_BAR_BYTES > 32'h8000_0000) begin : g_bad_bar
    $error("msixcap_regs: ORIG_BAR_BYTES above 2 GB");
  end
  if (BIR < 0 || BIR > 5) begin : g_bad_bir
    $error("msixcap_regs: BIR out of range");
  end

  logic en_q, mask_q, intx_q, rescan_q;
  logic ctrl_hit;
  logic unused_bits;

  assign ctrl_hit    = cfg_wr && cfg_be[3] && (cfg_addr == 2'd0);
  assign unused_bits = ^{cfg_wdata[29:0], cfg_be[2:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      mask_q   <= 1'b0;
      intx_q   <= 1'b0;
      rescan_q <= 1'b0;
    end else begin
      if (ctrl_hit) begin
        en_q   <= cfg_wdata[31];
        mask_q <= cfg_wdata[30];
      end
      intx_q   <= ctrl_hit && cfg_wdata[31];
      rescan_q <= ctrl_hit && cfg_wdata[31] && !cfg_wdata[30];
    end
  end

  always_comb begin
    case (cfg_addr)
      2'd0:    cfg_rdata = {en_q, mask_q, 3'b000, QSIZE, 8'h00, 8'h11};
      2'd1:    cfg_rdata = TBL;
      2'd2:    cfg_rdata = PBA;
      default: cfg_rdata = 32'h0;
    endcase
  end

  assign msix_en       = en_q;
  assign func_mask     = mask_q;
  assign intx_deassert = intx_q;
  assign rescan_req    = rescan_q;
  assign bar_size_new  = NEWSZ;
endmodule

module msixcap_regs_chk #(
  parameter int VEC_COUNT = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:2]  cfg_addr,
  input logic        cfg_wr,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_rdata,
  input logic        msix_en,
  input logic        func_mask,
  input logic        intx_deassert,
  input logic        rescan_req
);
  assert_ident_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 2'd0) |-> (cfg_rdata[7:0] == 8'h11 && cfg_rdata[26:16] == 11'(VEC_COUNT - 1)));

  assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr && cfg_be[3] && cfg_addr == 2'd0) |-> ($stable(msix_en) && $stable(func_mask)));

  assert_drop_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    intx_deassert |-> ($past(cfg_wr && cfg_be[3] && cfg_addr == 2'd0) && msix_en));

  assert_rescan_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rescan_req |-> (intx_deassert && !func_mask));

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !msix_en |-> (!intx_deassert && !rescan_req));
endmodule

bind msixcap_regs msixcap_regs_chk #(.VEC_COUNT(VEC_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
  .cfg_rdata(cfg_rdata), .msix_en(msix_en), .func_mask(func_mask),
  .intx_deassert(intx_deassert), .rescan_req(rescan_req)
);

// File: tb/msixcap_regs_test.sv
`timescale 1ns/1ps
module msixcap_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:2] cfg_addr = 2'd0;
  logic cfg_wr = 1'b0;
  logic [3:0] cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] rdata, rdata_z, rdata_s;
  logic en, msk, drop, rescan;
  logic en_z, msk_z, drop_z, rescan_z, en_s, msk_s, drop_s, rescan_s;
  logic [32:0] bsz, bsz_z, bsz_s;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  msixcap_regs #(.VEC_COUNT(32), .ORIG_BAR_BYTES(32'h4000), .BIR(2)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(rdata), .msix_en(en), .func_mask(msk),
    .intx_deassert(drop), .rescan_req(rescan), .bar_size_new(bsz));

  msixcap_regs #(.VEC_COUNT(1), .ORIG_BAR_BYTES(32'h0), .BIR(0)) uut_zero (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(1'b0), .cfg_be(4'h0),
    .cfg_wdata(32'h0), .cfg_rdata(rdata_z), .msix_en(en_z), .func_mask(msk_z),
    .intx_deassert(drop_z), .rescan_req(rescan_z), .bar_size_new(bsz_z));

  msixcap_regs #(.VEC_COUNT(5), .ORIG_BAR_BYTES(32'h100), .BIR(5)) uut_small (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(1'b0), .cfg_be(4'h0),
    .cfg_wdata(32'h0), .cfg_rdata(rdata_s), .msix_en(en_s), .func_mask(msk_s),
    .intx_deassert(drop_s), .rescan_req(rescan_s), .bar_size_new(bsz_s));

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a);
    cfg_addr = a;
    #0.5;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic next_cycle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    check("R2 enable after reset", en, 0);
    check("R2 mask after reset", msk, 0);
    check("R2 pulses after reset", {drop, rescan}, 0);
  endtask

  task automatic t_ident();
    rd(0);
    check("R1 dword0 default", rdata, 32'h001F_0011);
    check("R1 dword0 single vector", rdata_z, 32'h0000_0011);
    check("R1 dword0 five vectors", rdata_s, 32'h0004_0011);
  endtask

  task automatic t_layout();
    rd(1);
    check("R5 table large", rdata, 32'h4002);
    check("R5 table zero bar", rdata_z, 32'h0);
    check("R5 table small bar", rdata_s, 32'h1005);
    rd(2);
    check("R5 pba large", rdata, 32'h4802);
    check("R5 pba zero bar", rdata_z, 32'h800);
    check("R5 pba small bar", rdata_s, 32'h1805);
    rd(3);
    check("R5 dword3", rdata, 32'h0);
    check("R6 size large", bsz, 33'h8000);
    check("R6 size zero bar", bsz_z, 33'h1000);
    check("R6 size small bar", bsz_s, 33'h2000);
  endtask

  task automatic t_enable_unmasked();
    wr(0, 4'hF, 32'hBFFF_FFFF);
    check("R7 drop pulse", drop, 1);
    check("R8 rescan with drop", rescan, 1);
    check("R10 enable out", en, 1);
    check("R10 mask out", msk, 0);
    rd(0);
    check("R3 read-only bits kept", rdata, 32'h801F_0011);
    next_cycle();
    check("R7 drop one cycle", drop, 0);
    check("R8 rescan one cycle", rescan, 0);
  endtask

  task automatic t_enable_masked();
    wr(0, 4'h8, 32'hC000_0000);
    check("R7 drop pulse masked", drop, 1);
    check("R8 no rescan when masked", rescan, 0);
    check("R10 mask out set", msk, 1);
    rd(0);
    check("R3 both flags", rdata, 32'hC01F_0011);
    next_cycle();
    check("R7 drop ends", drop, 0);
  endtask

  task automatic t_ignored_writes();
    wr(0, 4'h7, 32'h0000_0000);
    check("R4 no be3 pulses", {drop, rescan}, 0);
    rd(0);
    check("R4 no be3 flags", rdata, 32'hC01F_0011);
    for (int a = 1; a < 4; a++) begin
      wr(a[1:0], 4'hF, 32'h0000_0000);
      check("R4 other dword pulses", {drop, rescan}, 0);
      check("R4 other dword flags", {en, msk}, 2'b11);
    end
    rd(1);
    check("R4 table unchanged", rdata, 32'h4002);
  endtask

  task automatic t_disable();
    wr(0, 4'h8, 32'h4000_0000);
    check("R9 no drop when disabled", drop, 0);
    check("R9 no rescan when disabled", rescan, 0);
    check("R10 enable cleared", en, 0);
    wr(0, 4'h8, 32'hC000_0000);
    rst_n = 1'b0;
    next_cycle();
    rst_n = 1'b1;
    check("R2 flags cleared by reset", {en, msk}, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ident();
    t_layout();
    t_enable_unmasked();
    t_enable_masked();
    t_ignored_writes();
    t_disable();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule